// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches 16-bit words from a small three-wire serial EEPROM by driving the pins directly from logic. A host asks for a word with a one-cycle request and an address. The block selects the part and clocks out a 16-bit read command, most significant bit first. It then clocks in the 16 data bits and releases the select. It returns the word with a single-cycle ready pulse.

Parts come in two address sizes. A size-detect input chooses between them when a request is accepted. With the input high, the command is 0x0180 combined with a 6-bit address. With it low, the command is 0x0600 combined with an 8-bit address. A programmable divider sets how many cycles each serial clock phase lasts, so the serial clock can be slowed to meet the part's minimum high and low times.

An optional boot sequencer runs straight after reset, before any host traffic is accepted. It reads words 0, 1 and 2 into a 48-bit station identifier and one configurable word into a 5-bit configuration register.

Top module: `eerd_top`

## Requirements
- R1: While reset is held, ee_cs_o, ee_sk_o, ee_di_o, ee_en_o and rd_rdy_o are all low.
- R2: The command is sent as 16 bits, most significant first, with each bit valid at the rising edge of ee_sk_o. When addr6_i is high at acceptance the command is 0x0180 OR rd_addr_i[5:0], and rd_addr_i[7:6] are ignored. When addr6_i is low the command is 0x0600 OR rd_addr_i[7:0].
- R3: ee_sk_o rises only while ee_cs_o is high. ee_di_o never changes while ee_sk_o is high. Each high time lasts PHASE_CYC cycles, and every low time inside a select is at least PHASE_CYC cycles.
- R4: Each select carries exactly 32 rising edges of ee_sk_o. The 16 data bits follow the 16 command bits, most significant first. Each data bit is the value of ee_do_i after the rising edge that presents it.
- R5: ee_en_o goes high with the first select and stays high. ee_cs_o falls after the 32nd pulse and before the ready pulse.
- R6: rd_rdy_o is high for exactly one cycle per accepted host request, and rd_data_o carries the read word in that cycle.
- R7: A request made while busy_o is high is ignored. It produces no extra select and no extra ready pulse.
- R8: With boot enabled, busy_o stays high from reset until boot_done_o rises, and boot_done_o then stays high. station_o holds word 0 in bits 15:0, word 1 in bits 31:16 and word 2 in bits 47:32, so byte k of the identifier sits at bits 8k+7:8k, low byte of each word first.
- R9: With boot enabled, cfg_o holds bits 4:0 of the word at address CFG_ADDR once boot_done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_i | input | 1 | One-cycle read request |
| rd_addr_i | input | 8 | Word address |
| addr6_i | input | 1 | Size detect: 1 selects 6-bit addressing |
| busy_o | output | 1 | Block is busy; requests are ignored |
| rd_rdy_o | output | 1 | One-cycle ready pulse |
| rd_data_o | output | 16 | Read word, valid with rd_rdy_o |
| ee_en_o | output | 1 | Serial interface enable |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| station_o | output | 48 | Station identifier from words 0 to 2 |
| cfg_o | output | 5 | Configuration bits from word CFG_ADDR |
| boot_done_o | output | 1 | Boot sequence finished |

## Verification
The bench builds the block with PHASE_CYC of 3, boot enabled and CFG_ADDR of 6. A phase of three cycles makes the measured high and low times distinct from the single-cycle case, so a divider fault shows up in the pin timing. Enabling boot puts the station and configuration loads, and the busy window they open, within reach. The address pattern covers both command forms, the extreme addresses 0x00 and 0xFF, and 6-bit truncation of upper address bits.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;
    localparam int BITS_PER_SEL = 2 * WORD_W;

    typedef enum logic [2:0] {
        X_IDLE  = 3'd0,
        X_SEL   = 3'd1,
        X_SET   = 3'd2,
        X_HIGH  = 3'd3,
        X_LOW   = 3'd4,
        X_DESEL = 3'd5
    } xfer_st_e;

    // Read command for either address size
    function automatic logic [WORD_W-1:0] mk_cmd(input logic six, input logic [ADDR_W-1:0] a);
        logic [WORD_W-1:0] c;
        if (six) c = 16'h0180 | {10'd0, a[5:0]};
        else     c = 16'h0600 | {8'd0, a};
        return c;
    endfunction

endpackage

// File: rtl/eerd_tick.sv
module eerd_tick #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eerd_xfer.sv
module eerd_xfer
    import eerd_pkg::*;
#(
    parameter int PHASE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              six_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ee_do_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] word_o,
    output logic              ee_cs_o,
    output logic              ee_sk_o,
    output logic              ee_di_o,
    output logic              ee_en_o
);
    localparam int IW = $clog2(BITS_PER_SEL);
    localparam logic [IW-1:0] LAST_BIT = IW'(BITS_PER_SEL - 1);

    typedef struct packed {
        xfer_st_e          st;
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] sh;
        logic [IW-1:0]     idx;
        logic              cs;
        logic              sk;
        logic              di;
        logic              en;
        logic              done;
    } xr_t;

    xr_t  r_d, r_q;
    logic tick;

    eerd_tick #(.PHASE_CYC(PHASE_CYC)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.st != X_IDLE),
        .tick_o (tick)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            X_IDLE: begin
                if (start_i) begin
                    r_d.st  = X_SEL;
                    r_d.cmd = mk_cmd(six_i, addr_i);
                    r_d.sh  = '0;
                    r_d.idx = '0;
                    r_d.cs  = 1'b1;
                    r_d.en  = 1'b1;
                    r_d.sk  = 1'b0;
                    r_d.di  = 1'b0;
                end
            end
            X_SEL: begin
                if (tick) begin
                    r_d.st  = X_SET;
                    r_d.di  = r_q.cmd[WORD_W-1];
                    r_d.cmd = {r_q.cmd[WORD_W-2:0], 1'b0};
                end
            end
            X_SET: begin
                if (tick) begin
                    r_d.sk = 1'b1;
                    r_d.st = X_HIGH;
                end
            end
            X_HIGH: begin
                if (tick) begin
                    r_d.sk = 1'b0;
                    r_d.st = X_LOW;
                end
            end
            X_LOW: begin
                if (tick) begin
                    if (r_q.idx[IW-1]) r_d.sh = {r_q.sh[WORD_W-2:0], ee_do_i};
                    if (r_q.idx == LAST_BIT) begin
                        r_d.st = X_DESEL;
                        r_d.cs = 1'b0;
                        r_d.di = 1'b0;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = X_SET;
                        r_d.di  = r_q.cmd[WORD_W-1];
                        r_d.cmd = {r_q.cmd[WORD_W-2:0], 1'b0};
                    end
                end
            end
            X_DESEL: begin
                if (tick) begin
                    r_d.st   = X_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = X_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: X_IDLE, cmd: '0, sh: '0, idx: '0,
                     cs: 1'b0, sk: 1'b0, di: 1'b0, en: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o  = (r_q.st != X_IDLE);
    assign done_o  = r_q.done;
    assign word_o  = r_q.sh;
    assign ee_cs_o = r_q.cs;
    assign ee_sk_o = r_q.sk;
    assign ee_di_o = r_q.di;
    assign ee_en_o = r_q.en;
endmodule

// File: rtl/eerd_boot.sv
module eerd_boot
    import eerd_pkg::*;
#(
    parameter int N_ID     = 3,
    parameter int CFG_ADDR = 6,
    parameter int CFG_BITS = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     done_i,
    input  logic [WORD_W-1:0]        word_i,
    output logic                     req_o,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [WORD_W*N_ID-1:0]   station_o,
    output logic [CFG_BITS-1:0]      cfg_o,
    output logic                     done_o
);
    localparam int STN_W  = WORD_W * N_ID;
    localparam int STEP_W = $clog2(N_ID + 1);
    localparam logic [STEP_W-1:0] CFG_STEP = STEP_W'(N_ID);

    typedef struct packed {
        logic [STEP_W-1:0]   step;
        logic                pend;
        logic                fin;
        logic [STN_W-1:0]    stn;
        logic [CFG_BITS-1:0] cfg;
    } br_t;

    br_t b_d, b_q;

    always_comb begin
        b_d    = b_q;
        req_o  = !b_q.fin && !b_q.pend;
        addr_o = (b_q.step == CFG_STEP) ? ADDR_W'(CFG_ADDR) : ADDR_W'(b_q.step);
        if (req_o) b_d.pend = 1'b1;
        if (b_q.pend && done_i) begin
            b_d.pend = 1'b0;
            if (b_q.step == CFG_STEP) begin
                b_d.cfg = word_i[CFG_BITS-1:0];
                b_d.fin = 1'b1;
            end else begin
                b_d.stn[WORD_W*b_q.step +: WORD_W] = word_i;
                b_d.step = b_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign station_o = b_q.stn;
    assign cfg_o     = b_q.cfg;
    assign done_o    = b_q.fin;
endmodule

// File: rtl/eerd_top.sv
module eerd_top
    import eerd_pkg::*;
#(
    parameter int PHASE_CYC = 4,
    parameter bit BOOT_EN   = 1'b1,
    parameter int N_ID      = 3,
    parameter int CFG_ADDR  = 6,
    parameter int CFG_BITS  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_req_i,
    input  logic [ADDR_W-1:0]      rd_addr_i,
    input  logic                   addr6_i,
    output logic                   busy_o,
    output logic                   rd_rdy_o,
    output logic [WORD_W-1:0]      rd_data_o,
    output logic                   ee_en_o,
    output logic                   ee_cs_o,
    output logic                   ee_sk_o,
    output logic                   ee_di_o,
    input  logic                   ee_do_i,
    output logic [WORD_W*N_ID-1:0] station_o,
    output logic [CFG_BITS-1:0]    cfg_o,
    output logic                   boot_done_o
);
    typedef struct packed {
        logic host;
    } tr_t;

    tr_t  t_d, t_q;
    logic x_start, x_busy, x_done;
    logic [WORD_W-1:0] x_word;
    logic [ADDR_W-1:0] x_addr;
    logic boot_req;
    logic [ADDR_W-1:0] boot_addr;
    logic host_go;

    generate
        if (BOOT_EN) begin : g_boot
            eerd_boot #(.N_ID(N_ID), .CFG_ADDR(CFG_ADDR), .CFG_BITS(CFG_BITS)) u_boot (
                .clk       (clk),
                .rst_n     (rst_n),
                .done_i    (x_done),
                .word_i    (x_word),
                .req_o     (boot_req),
                .addr_o    (boot_addr),
                .station_o (station_o),
                .cfg_o     (cfg_o),
                .done_o    (boot_done_o)
            );
        end else begin : g_noboot
            assign boot_req    = 1'b0;
            assign boot_addr   = '0;
            assign station_o   = '0;
            assign cfg_o       = '0;
            assign boot_done_o = 1'b1;
        end
    endgenerate

    eerd_xfer #(.PHASE_CYC(PHASE_CYC)) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (x_start),
        .six_i   (addr6_i),
        .addr_i  (x_addr),
        .ee_do_i (ee_do_i),
        .busy_o  (x_busy),
        .done_o  (x_done),
        .word_o  (x_word),
        .ee_cs_o (ee_cs_o),
        .ee_sk_o (ee_sk_o),
        .ee_di_o (ee_di_o),
        .ee_en_o (ee_en_o)
    );

    always_comb begin
        busy_o  = x_busy || !boot_done_o;
        host_go = rd_req_i && !busy_o;
        x_start = boot_done_o ? host_go : boot_req;
        x_addr  = boot_done_o ? rd_addr_i : boot_addr;
        t_d     = t_q;
        if (host_go)     t_d.host = 1'b1;
        else if (x_done) t_d.host = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rd_rdy_o  = x_done && t_q.host;
    assign rd_data_o = x_word;
endmodule

// File: rtl/eerd_chk.sv
module eerd_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic rd_rdy_o,
    input logic ee_en_o,
    input logic ee_cs_o,
    input logic ee_sk_o,
    input logic ee_di_o,
    input logic boot_done_o
);
    AST_RDY_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) rd_rdy_o |=> !rd_rdy_o); // R6
    AST_SK_NEEDS_CS:  assert property (@(posedge clk) disable iff (!rst_n) ee_sk_o |-> ee_cs_o); // R3
    AST_DI_HELD:      assert property (@(posedge clk) disable iff (!rst_n) (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o)); // R3
    AST_EN_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) ee_en_o |=> ee_en_o); // R5
    AST_RDY_DESEL:    assert property (@(posedge clk) disable iff (!rst_n) rd_rdy_o |-> (!ee_cs_o && ee_en_o)); // R5
    AST_SEL_BUSY:     assert property (@(posedge clk) disable iff (!rst_n) ee_cs_o |-> busy_o); // R7
    AST_BOOT_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) !boot_done_o |-> busy_o); // R8
    AST_BOOT_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) boot_done_o |=> boot_done_o); // R8
endmodule

bind eerd_top eerd_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .rd_rdy_o    (rd_rdy_o),
    .ee_en_o     (ee_en_o),
    .ee_cs_o     (ee_cs_o),
    .ee_sk_o     (ee_sk_o),
    .ee_di_o     (ee_di_o),
    .boot_done_o (boot_done_o)
);

// File: tb/eerd_top_tb_top.sv
module eerd_top_tb_top;
    localparam int TB_PHASE = 3;
    localparam int TB_CFG   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_addr = 8'h00;
    logic        addr6 = 1'b1;
    logic        busy, rdy, en, cs, sk, di;
    logic        ee_do = 1'b0;
    logic [15:0] rdata;
    logic [47:0] station;
    logic [4:0]  cfg;
    logic        bdone;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // EEPROM model observations
    int          selects = 0;
    int          bits = 0;
    int          pulses_last = 0;
    int          viol = 0;
    int          hi_len = 0;
    int          lo_len = 0;
    int          min_hi = 1000;
    int          rdy_cnt = 0;
    logic [15:0] cmd_sh = '0;
    logic [15:0] last_cmd = '0;
    logic [15:0] send = '0;
    logic        cs_p = 1'b0, sk_p = 1'b0, di_p = 1'b0;

    always #5 clk = ~clk;

    eerd_top #(.PHASE_CYC(TB_PHASE), .BOOT_EN(1'b1), .N_ID(3), .CFG_ADDR(TB_CFG), .CFG_BITS(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr), .addr6_i(addr6),
        .busy_o(busy), .rd_rdy_o(rdy), .rd_data_o(rdata), .ee_en_o(en), .ee_cs_o(cs),
        .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(ee_do), .station_o(station), .cfg_o(cfg),
        .boot_done_o(bdone)
    );

    function automatic logic [15:0] mem_word(input logic [7:0] a);
        return {a, ~a} ^ 16'h3C5A;
    endfunction

    function automatic logic [7:0] model_addr(input logic [15:0] c);
        if (c[15:6] == 10'h006) return {2'b00, c[5:0]};
        return c[7:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            bits = 0; cs_p = 1'b0; sk_p = 1'b0; di_p = 1'b0;
        end else begin
            if (rdy) rdy_cnt++;
            if (cs && !cs_p) begin selects++; bits = 0; lo_len = 0; end
            if (!cs && cs_p) pulses_last = bits;
            if (cs) begin
                if (sk && !sk_p) begin
                    if (lo_len < TB_PHASE) viol++;
                    hi_len = 1;
                    if (bits < 16) begin
                        cmd_sh = {cmd_sh[14:0], di};
                        if (bits == 15) begin
                            last_cmd = cmd_sh;
                            send = mem_word(model_addr(cmd_sh));
                        end
                    end else if (bits < 32) begin
                        ee_do <= send[31-bits];
                    end
                    bits++;
                end else if (sk) begin
                    hi_len++;
                    if (di != di_p) viol++;
                end else if (sk_p) begin
                    if (hi_len < TB_PHASE) viol++;
                    if (hi_len < min_hi) min_hi = hi_len;
                    lo_len = 1;
                end else begin
                    lo_len++;
                end
            end else if (sk) begin
                viol++;
            end
            cs_p = cs; sk_p = sk; di_p = di;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic do_read(input logic [7:0] a, input logic six, input string req);
        logic [7:0]  ea;
        logic [15:0] ec;
        int n = 0;
        wait_idle();
        @(negedge clk); rd_req = 1'b1; rd_addr = a; addr6 = six;
        @(negedge clk); rd_req = 1'b0;
        while (!rdy && n < 5000) begin @(negedge clk); n++; end
        ea = six ? {2'b00, a[5:0]} : a;
        ec = six ? (16'h0180 | {8'd0, ea}) : (16'h0600 | {8'd0, a});
        chk(rdy == 1'b1, {req, " R6 ready"}, 64'(rdy), 1);
        chk(rdata == mem_word(ea), {req, " R4 R6 data"}, 64'(rdata), 64'(mem_word(ea)));
        chk(last_cmd == ec, {req, " R2 command"}, 64'(last_cmd), 64'(ec));
        chk(pulses_last == 32, {req, " R4 pulses"}, 64'(pulses_last), 32);
        chk(!cs && en, {req, " R5 desel/en"}, 64'({cs, en}), 64'b01);
        @(negedge clk);
        chk(!rdy, {req, " R6 single pulse"}, 64'(rdy), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk({cs, sk, di, en, rdy} == 5'b0, "R1 reset pins", 64'({cs, sk, di, en, rdy}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy during boot", 64'(busy), 1);
    endtask

    task automatic t_boot();
        int n = 0;
        int r0;
        r0 = rdy_cnt;
        @(negedge clk); rd_req = 1'b1; rd_addr = 8'h33;
        @(negedge clk); rd_req = 1'b0;
        while (!bdone && n < 20000) begin @(negedge clk); n++; end
        chk(bdone == 1'b1, "R8 boot done", 64'(bdone), 1);
        chk(station == {mem_word(8'd2), mem_word(8'd1), mem_word(8'd0)}, "R8 station",
            64'(station), 64'({mem_word(8'd2), mem_word(8'd1), mem_word(8'd0)}));
        chk(station[7:0] == mem_word(8'd0) [7:0], "R8 byte0 low first", 64'(station[7:0]), 64'(mem_word(8'd0) [7:0]));
        chk(cfg == mem_word(8'(TB_CFG)) [4:0], "R9 cfg", 64'(cfg), 64'(mem_word(8'(TB_CFG)) [4:0]));
        chk(selects == 4, "R7 R8 boot selects", 64'(selects), 4);
        chk(rdy_cnt == r0, "R7 request during boot ignored", 64'(rdy_cnt), 64'(r0));
    endtask

    task automatic t_busy_ignore();
        int s0, r0, n;
        s0 = selects; r0 = rdy_cnt; n = 0;
        wait_idle();
        @(negedge clk); rd_req = 1'b1; rd_addr = 8'h11; addr6 = 1'b0;
        @(negedge clk); rd_req = 1'b0;
        repeat (20) @(negedge clk);
        rd_req = 1'b1; rd_addr = 8'h22;
        @(negedge clk); rd_req = 1'b0;
        while (!rdy && n < 5000) begin @(negedge clk); n++; end
        chk(rdata == mem_word(8'h11), "R7 first word kept", 64'(rdata), 64'(mem_word(8'h11)));
        repeat (400) @(negedge clk);
        chk(selects == s0 + 1, "R7 no extra select", 64'(selects), 64'(s0 + 1));
        chk(rdy_cnt == r0 + 1, "R7 no extra ready", 64'(rdy_cnt), 64'(r0 + 1));
    endtask

    task automatic t_timing();
        chk(viol == 0, "R3 clock/data timing", 64'(viol), 0);
        chk(min_hi == TB_PHASE, "R3 high time", 64'(min_hi), 64'(TB_PHASE));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_boot();
        do_read(8'hE5, 1'b1, "six-bit truncation");
        do_read(8'h3F, 1'b1, "six-bit max");
        do_read(8'hC7, 1'b0, "eight-bit");
        do_read(8'hFF, 1'b0, "eight-bit max");
        do_read(8'h00, 1'b0, "eight-bit zero");
        t_busy_ignore();
        t_timing();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule